// File: doc/BRIEF.md
# Metering Pulse Width Limiter

This block turns a stream of single-cycle pulse requests into output pulses whose width is bounded in units of a timing tick. Each accepted request starts a pulse. The pulse ends after a programmed number of ticks. When the width setting holds its all-ones value, width limiting is switched off and each request toggles the output level instead, which gives a 50% duty square wave at half the request rate. By default the pulse is low. An invert input makes the active level high.

The tick comes from one of two sources. When the interval setting is zero, the tick is an external fixed sample-period strobe. When the interval setting is nonzero, a free-running counter divides the clock by that value. When the interval is nonzero, a request that arrives while a pulse is active, or while earlier requests are still waiting, is held in a four-deep queue. Held requests are released one per tick once the output is idle. When the interval is zero there is no queue: a request that arrives during a pulse restarts it at once.

Top module: `pwl_pulse_limiter`

## Requirements
- R1: While reset is asserted and immediately after it is released, `pulse_out` equals the inactive level (1 with `cfg_invert`=0) and `overflow` is 0.
- R2: With `cfg_interval`=0 and `cfg_max_width`=N (N below 255), a pulse lasts exactly 2N+1 `sample_tick` strobes: strobes sampled while the output is active are counted, and the output goes inactive on the edge that samples strobe number 2N+1.
- R3: With `cfg_interval`=I (nonzero), a tick occurs every I clock cycles, so a pulse of N lasts between 2N·I+1 and (2N+1)·I clock cycles.
- R4: With `cfg_max_width`=255, every request inverts the output level on the next clock edge, whatever the interval setting. Ticks have no effect on the level in this mode.
- R5: With `cfg_interval`=0, a request that arrives during an active pulse restarts it: the output stays active, and a full 2N+1 strobes are counted from the restart.
- R6: With `cfg_interval` nonzero, a request that arrives during an active pulse is queued. It starts a new pulse on the first tick after the current pulse ends, so the output is inactive for exactly I cycles between the two pulses.
- R7: The queue holds 4 requests. A request that arrives while the queue is full is dropped, and `overflow` goes to 1 and stays at 1 until reset.
- R8: With `cfg_invert`=1 the active level of `pulse_out` is 1 and the inactive level is 0. With `cfg_invert`=0 the levels are the reverse.
- R9: A request that arrives while the output is idle and no requests are queued makes the output active on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Fixed sample-period strobe, used as the tick when the interval is 0 |
| pulse_req | input | 1 | One-cycle pulse request |
| cfg_max_width | input | 8 | Width setting N (width is 2N+1 ticks; 255 selects toggle mode) |
| cfg_interval | input | 8 | Tick divider (0 selects the sample strobe and bypasses the queue) |
| cfg_invert | input | 1 | Makes the active level high |
| pulse_out | output | 1 | Shaped pulse output |
| overflow | output | 1 | Sticky flag: a request was dropped because the queue was full |

## Verification
A wrong width count shows up at the end of the first pulse, as an edge one or more ticks early or late. A tick divider that is out of phase or at the wrong period shifts pulse lengths outside the window of R3, and it also changes the idle gap between queued pulses, which is exactly one interval. A queue occupancy that is wrong by one shows up later, as a missing or an extra pulse in the burst that drains after an overload, and as `overflow` being set one request too early or too late.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int WW = 8;           // width setting bits
  localparam int CW = WW + 1;      // width counter bits (holds 2N)

  // Index of the tick that ends a pulse: ticks are numbered 0..2N.
  function automatic logic [CW-1:0] last_tick_idx(input logic [WW-1:0] n);
    return {n, 1'b0};
  endfunction

  // All-ones setting selects 50% duty toggle mode.
  function automatic logic is_toggle_mode(input logic [WW-1:0] n);
    return n == {WW{1'b1}};
  endfunction

  // Terminal count of the interval divider.
  function automatic logic [WW-1:0] div_last(input logic [WW-1:0] iv);
    return iv - {{(WW-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/pwl_tick_gen.sv
module pwl_tick_gen
  import pwl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic [WW-1:0] interval,
  output logic          tick
);
  logic [WW-1:0] cnt;
  logic          div_wrap;

  assign div_wrap = (cnt >= div_last(interval));
  assign tick     = (interval == '0) ? sample_tick : div_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || interval == '0) cnt <= '0;
    else if (div_wrap)            cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  // R3: with a steady divider above 1, two ticks never fall on adjacent cycles
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (interval > 8'd1 && tick) |=> (!tick || interval != $past(interval)));
endmodule

// File: rtl/pwl_req_queue.sv
module pwl_req_queue #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic empty,
  output logic overflow
);
  localparam int QW = $clog2(DEPTH + 1);

  logic [QW-1:0] occ;
  logic          full;
  logic          drop_evt;
  logic          push_ok;

  assign empty    = (occ == '0);
  assign full     = (occ == QW'(DEPTH));
  assign drop_evt = push && full && !pop;
  assign push_ok  = push && !drop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok && !pop)      occ <= occ + 1'b1;
      else if (pop && !push_ok) occ <= occ - 1'b1;
      if (drop_evt) overflow <= 1'b1;
    end
  end

  assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= QW'(DEPTH));
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);
  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/pwl_width_ctl.sv
module pwl_width_ctl
  import pwl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          toggle_req,
  input  logic [WW-1:0] max_width,
  output logic          active
);
  logic [CW-1:0] wcnt;
  logic          toggle_mode;
  logic          end_evt;

  assign toggle_mode = is_toggle_mode(max_width);
  assign end_evt     = active && tick && !toggle_mode && (wcnt == last_tick_idx(max_width));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      wcnt   <= '0;
    end else if (start) begin
      active <= 1'b1;
      wcnt   <= '0;
    end else if (toggle_req) begin
      active <= ~active;
      wcnt   <= '0;
    end else if (end_evt) begin
      active <= 1'b0;
    end else if (active && tick && !toggle_mode) begin
      wcnt   <= wcnt + 1'b1;
    end
  end

  assert_end_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !start && !toggle_req) |=> !active);
  assert_toggle_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_req && !start) |=> (active != $past(active)));
  assert_start_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
endmodule

// File: rtl/pwl_pulse_limiter.sv
module pwl_pulse_limiter
  import pwl_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       pulse_req,
  input  logic [7:0] cfg_max_width,
  input  logic [7:0] cfg_interval,
  input  logic       cfg_invert,
  output logic       pulse_out,
  output logic       overflow
);
  logic tick;
  logic active;
  logic q_empty;
  logic toggle_mode;
  logic bypass;
  logic busy;
  logic start_now;
  logic q_push;
  logic q_pop;
  logic toggle_req;

  assign toggle_mode = is_toggle_mode(cfg_max_width);
  assign bypass      = (cfg_interval == '0);
  assign busy        = active || !q_empty;
  assign toggle_req  = pulse_req && toggle_mode;
  assign start_now   = pulse_req && !toggle_mode && (bypass || !busy);
  assign q_push      = pulse_req && !toggle_mode && !bypass && busy;
  assign q_pop       = !bypass && !toggle_mode && !active && !q_empty && tick;

  pwl_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .interval(cfg_interval), .tick(tick)
  );

  pwl_req_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .pop(q_pop),
    .empty(q_empty), .overflow(overflow)
  );

  pwl_width_ctl u_width (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_now || q_pop),
    .toggle_req(toggle_req), .max_width(cfg_max_width), .active(active)
  );

  assign pulse_out = active ? cfg_invert : ~cfg_invert;

  assert_bypass_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_req && bypass && !toggle_mode) |=> active);
  assert_queue_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && active) |=> (active || !q_empty || overflow));
  assert_idle_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_req && !toggle_mode && !busy) |=> active);
endmodule

// File: tb/sim_pwl_pulse_limiter.sv
module sim_pwl_pulse_limiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       pulse_req = 1'b0;
  logic [7:0] cfg_max_width = 8'hFF;
  logic [7:0] cfg_interval = 8'd0;
  logic       cfg_invert = 1'b0;
  logic       pulse_out;
  logic       overflow;

  int nchk = 0;
  int nfail = 0;

  // Vectors: {N, invert}
  localparam logic [8:0] VEC [5] = '{
    {8'd0, 1'b0}, {8'd1, 1'b0}, {8'd3, 1'b1}, {8'd10, 1'b0}, {8'd254, 1'b1}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pwl_pulse_limiter u0 (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pulse_req(pulse_req),
    .cfg_max_width(cfg_max_width), .cfg_interval(cfg_interval),
    .cfg_invert(cfg_invert), .pulse_out(pulse_out), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic bit is_act();
    return cfg_invert ? pulse_out : !pulse_out;
  endfunction

  // Drive inputs at a falling edge, return at the next falling edge.
  task automatic step(input logic r, input logic t);
    pulse_req   = r;
    sample_tick = t;
    @(posedge clk);
    @(negedge clk);
    pulse_req   = 1'b0;
    sample_tick = 1'b0;
  endtask

  // Count strobes sampled while active, strobe every 3rd cycle, until idle.
  task automatic count_ticks(output int ticks);
    ticks = 0;
    for (int c = 0; c < 3000; c++) begin
      bit pre = is_act();
      bit tk = (c % 3 == 2);
      step(1'b0, tk);
      if (pre && tk) ticks++;
      if (!is_act()) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int ticks;
    int len;
    int starts;
    int gap;
    int cur_gap;
    bit prev;
    @(negedge clk);
    step(0, 0);
    // R1 during reset
    chk(pulse_out == 1'b1, "R1 reset level", pulse_out, 1);
    chk(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    rst_n = 1'b1;
    step(0, 0);
    chk(pulse_out == 1'b1, "R1 after reset", pulse_out, 1);

    // R2/R8/R9 table walk in bypass mode
    for (int i = 0; i < 5; i++) begin
      cfg_max_width = VEC[i][8:1];
      cfg_invert    = VEC[i][0];
      step(0, 0);
      chk(pulse_out == !cfg_invert, "R8 idle level", pulse_out, !cfg_invert);
      step(1, 0);
      chk(is_act(), "R9 start next edge", is_act(), 1);
      chk(pulse_out == cfg_invert, "R8 active level", pulse_out, cfg_invert);
      count_ticks(ticks);
      chk(ticks == 2*int'(VEC[i][8:1]) + 1, "R2 width in ticks", ticks,
          2*int'(VEC[i][8:1]) + 1);
    end
    cfg_invert = 1'b0;

    // R5: bypass retrigger
    cfg_max_width = 8'd1;
    step(1, 0);
    step(0, 1);
    step(0, 1);
    chk(is_act(), "R5 still active before retrigger", is_act(), 1);
    step(1, 0);
    chk(is_act(), "R5 active after retrigger", is_act(), 1);
    count_ticks(ticks);
    chk(ticks == 3, "R5 full width after retrigger", ticks, 3);

    // R4: toggle mode, bypass then divided
    cfg_max_width = 8'hFF;
    step(1, 0);
    chk(is_act(), "R4 first toggle", is_act(), 1);
    for (int c = 0; c < 9; c++) step(0, 1);
    chk(is_act(), "R4 ticks ignored", is_act(), 1);
    step(1, 0);
    chk(!is_act(), "R4 second toggle", is_act(), 0);
    cfg_interval = 8'd4;
    step(1, 0);
    chk(is_act(), "R4 toggle with divider", is_act(), 1);
    for (int c = 0; c < 12; c++) step(0, 0);
    chk(is_act(), "R4 divider ticks ignored", is_act(), 1);
    step(1, 0);
    chk(!is_act(), "R4 toggle back", is_act(), 0);

    // R3: divided tick, I=5, N=2 -> 21..25 cycles
    cfg_interval  = 8'd5;
    cfg_max_width = 8'd2;
    step(0, 0);
    step(1, 0);
    len = 1;
    for (int c = 0; c < 200; c++) begin
      step(0, 0);
      if (is_act()) len++;
      else break;
    end
    chk(len >= 21 && len <= 25, "R3 divided width", len, 21);

    // R6: queued request, I=3, N=1
    cfg_interval  = 8'd3;
    cfg_max_width = 8'd1;
    step(0, 0);
    step(1, 0);
    step(0, 0);
    step(1, 0);
    starts = 1; gap = 0; cur_gap = 0; prev = is_act();
    for (int c = 0; c < 60; c++) begin
      step(0, 0);
      if (!is_act()) cur_gap++;
      if (is_act() && !prev) begin
        starts++;
        gap = cur_gap;
      end
      if (is_act()) cur_gap = 0;
      prev = is_act();
    end
    chk(starts == 2, "R6 queued pulse count", starts, 2);
    chk(gap == 3, "R6 idle gap equals interval", gap, 3);
    chk(overflow == 1'b0, "R7 no overflow yet", overflow, 0);

    // R7: overload, I=2, N=3
    cfg_interval  = 8'd2;
    cfg_max_width = 8'd3;
    step(0, 0);
    for (int c = 0; c < 5; c++) step(1, 0);
    chk(overflow == 1'b0, "R7 four queued no overflow", overflow, 0);
    step(1, 0);
    chk(overflow == 1'b1, "R7 fifth extra dropped", overflow, 1);
    starts = 1; prev = is_act();
    for (int c = 0; c < 300; c++) begin
      step(0, 0);
      if (is_act() && !prev) starts++;
      prev = is_act();
    end
    chk(starts == 5, "R7 pulses after overload", starts, 5);
    chk(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule